// File: doc/BRIEF.md
# Controller Power-Up Reset Sequencer

This block brings a serial-link controller and its PHY out of power-down in a fixed, timed order. A single `start_i` pulse makes it turn on the supply, enable the three controller clocks one after another, lift the PHY power-down and, after a short hold, enable the reference clock. It then waits for the clocks to settle and holds the external endpoint reset active for a long, parameterised time. After that the reset is released and one of four variant-specific tails runs. The active level of the endpoint reset is set by `ep_pol_i`.

The four variants, captured at start, are: plain (0), which has no extra step; PHY-reset (1), which releases the PHY reset for one cycle before finishing; soft-reset (2), which releases the core soft reset and then waits; and PLL-wait (3), which releases the PHY reset and polls the PLL-lock input a bounded number of times with a gap between polls. If the lock never arrives, PLL-wait raises a timeout flag but still completes the sequence. Completion is marked by a one-cycle `done_o` and a persistent `up_o`. A `shutdown_i` pulse from any active state takes the block through a one-cycle power-down state back to idle.

States: IDLE, SUPPLY, PHYCLK, BUSCLK, CORECLK, PDREL, SETTLE, EPHOLD, EPREL, PHYREL, POLL, GAP, SOFTREL, FIN, UP and DOWN.
- IDLE goes to SUPPLY on start.
- The chain SUPPLY, PHYCLK, BUSCLK, CORECLK, PDREL, SETTLE, EPHOLD, EPREL advances each time a state's timer expires.
- EPREL goes to FIN, PHYREL or SOFTREL according to the variant.
- PHYREL goes to POLL for PLL-wait and to FIN otherwise.
- POLL goes to FIN on lock or on the last poll, and to GAP otherwise. GAP goes back to POLL.
- SOFTREL goes to FIN. FIN goes to UP.
- Any state other than IDLE and DOWN goes to DOWN on shutdown, and DOWN goes to IDLE.

Top module: `pwrup_rst_seq`

## Requirements
- R1: Out of reset, the block is in IDLE with these outputs: supply, all clocks and the reference clock off; PHY power-down high; PHY reset and core soft reset high; endpoint reset active; busy, done, up and lock timeout low.
- R2: Sampling `start_i` high in IDLE turns the supply on after that edge for SUPPLY_CYC cycles. The PHY, bus and core clocks then turn on in that order, one cycle apart. A later clock is never on without the earlier ones.
- R3: One cycle after the core clock turns on, PHY power-down drops. The reference clock turns on PD2REF_CYC cycles later and is never on while the PHY is powered down.
- R4: The endpoint reset stays active until SETTLE_CYC + EPRST_CYC cycles after the reference clock turns on, and then goes inactive. It is inactive only while the reference clock runs.
- R5: `ep_rst_o` equals `ep_pol_i` while the reset is active and equals its inverse while released, and it follows a change of `ep_pol_i` in the same cycle.
- R6: In variant 0, FIN follows one cycle after the endpoint reset is released. In variant 1, a one-cycle PHY-reset release comes in between. In FIN and UP both resets are released and `up_o` is high.
- R7: In variant 2, the core soft reset is released for SOFT_CYC cycles before FIN while the PHY reset stays high.
- R8: In variant 3, one cycle after the PHY reset is released the lock input is sampled. Each failed sample is followed by GAP_CYC cycles before the next one, and a high sample leads to FIN on the next cycle.
- R9: After POLL_MAX failed samples, `lock_to_o` is set and FIN is still reached. A lock seen on the last sample wins and leaves the flag low. The flag is cleared by the next start.
- R10: `done_o` is high for exactly the one FIN cycle. `busy_o` is high from SUPPLY to the last cycle before FIN and in DOWN, and never together with `done_o`.
- R11: `start_i` has no effect outside IDLE.
- R12: `shutdown_i` outside IDLE and DOWN leads next cycle to DOWN: supply on; clocks, reference clock, done and up off; power-down and both resets high; endpoint reset active. The cycle after that is IDLE. Shutdown wins over a timer expiry in the same cycle, and start and shutdown together in IDLE leave the block in IDLE.
- R13: The variant is captured when the sequence starts; later changes of `variant_i` do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the power-up sequence (IDLE only) |
| shutdown_i | input | 1 | Return to powered-down idle |
| pll_lock_i | input | 1 | PHY PLL locked |
| ep_pol_i | input | 1 | Active level of the endpoint reset |
| variant_i | input | 2 | Tail variant: 0 plain, 1 PHY reset, 2 soft reset, 3 PLL wait |
| supply_en_o | output | 1 | Supply enable |
| phy_clk_en_o | output | 1 | PHY clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| core_clk_en_o | output | 1 | Core clock enable |
| phy_pd_o | output | 1 | PHY power-down, high = powered down |
| ref_clk_en_o | output | 1 | Reference clock enable |
| ep_rst_o | output | 1 | Endpoint reset, active level set by ep_pol_i |
| phy_rst_o | output | 1 | PHY reset, high = held |
| core_srst_o | output | 1 | Core soft reset, high = held |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| up_o | output | 1 | Sequence complete, link side released |
| lock_to_o | output | 1 | PLL lock wait timed out |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both. In the first, `shutdown_i` is timed to be sampled on the exact edge where the SUPPLY timer expires; the check is that DOWN is entered and the PHY clock never turns on. In the second, the PLL lock first arrives on the final permitted poll, when the timeout would otherwise fire; the check is that FIN comes at the timeout latency but `lock_to_o` stays low. Start and shutdown are also raised together in IDLE. A behavioural reference model checks every output on every cycle.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SUPPLY,
        ST_PHYCLK,
        ST_BUSCLK,
        ST_CORECLK,
        ST_PDREL,
        ST_SETTLE,
        ST_EPHOLD,
        ST_EPREL,
        ST_PHYREL,
        ST_POLL,
        ST_GAP,
        ST_SOFTREL,
        ST_FIN,
        ST_UP,
        ST_DOWN
    } prs_state_e;

    typedef enum logic [1:0] {
        VAR_PLAIN   = 2'd0,
        VAR_PHYRST  = 2'd1,
        VAR_SOFTRST = 2'd2,
        VAR_PLLWAIT = 2'd3
    } prs_variant_e;

    typedef struct packed {
        logic supply;
        logic phy_clk;
        logic bus_clk;
        logic core_clk;
        logic phy_pd;
        logic ref_clk;
        logic ep_assert;
        logic phy_rst;
        logic core_srst;
        logic busy;
        logic done;
        logic up;
    } prs_out_t;

    function automatic int prs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prs_timer.sv
module prs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // Step timing of R2/R3/R4 relies on a steady one-per-cycle countdown.
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/prs_poll_ctr.sv
module prs_poll_ctr #(
    parameter int POLL_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic last
);

    localparam int PW = $clog2(POLL_MAX + 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (incr) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == PW'(POLL_MAX - 1));

    // Failed samples never exceed the bound (R9).
    assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < PW'(POLL_MAX));

endmodule

// File: rtl/prs_out_decode.sv
module prs_out_decode
    import prs_pkg::*;
(
    input  prs_state_e state,
    output prs_out_t   outs
);

    always_comb begin
        outs = '{supply: 1'b0, phy_clk: 1'b0, bus_clk: 1'b0, core_clk: 1'b0,
                 phy_pd: 1'b1, ref_clk: 1'b0, ep_assert: 1'b1, phy_rst: 1'b1,
                 core_srst: 1'b1, busy: 1'b0, done: 1'b0, up: 1'b0};
        unique case (state)
            ST_IDLE: begin
            end
            ST_SUPPLY: begin
                outs.supply = 1'b1;
                outs.busy   = 1'b1;
            end
            ST_PHYCLK: begin
                outs.supply  = 1'b1;
                outs.phy_clk = 1'b1;
                outs.busy    = 1'b1;
            end
            ST_BUSCLK: begin
                outs.supply  = 1'b1;
                outs.phy_clk = 1'b1;
                outs.bus_clk = 1'b1;
                outs.busy    = 1'b1;
            end
            ST_CORECLK: begin
                outs.supply   = 1'b1;
                outs.phy_clk  = 1'b1;
                outs.bus_clk  = 1'b1;
                outs.core_clk = 1'b1;
                outs.busy     = 1'b1;
            end
            ST_PDREL: begin
                outs.supply   = 1'b1;
                outs.phy_clk  = 1'b1;
                outs.bus_clk  = 1'b1;
                outs.core_clk = 1'b1;
                outs.phy_pd   = 1'b0;
                outs.busy     = 1'b1;
            end
            ST_SETTLE, ST_EPHOLD: begin
                outs.supply   = 1'b1;
                outs.phy_clk  = 1'b1;
                outs.bus_clk  = 1'b1;
                outs.core_clk = 1'b1;
                outs.phy_pd   = 1'b0;
                outs.ref_clk  = 1'b1;
                outs.busy     = 1'b1;
            end
            ST_EPREL: begin
                outs.supply    = 1'b1;
                outs.phy_clk   = 1'b1;
                outs.bus_clk   = 1'b1;
                outs.core_clk  = 1'b1;
                outs.phy_pd    = 1'b0;
                outs.ref_clk   = 1'b1;
                outs.ep_assert = 1'b0;
                outs.busy      = 1'b1;
            end
            ST_PHYREL, ST_POLL, ST_GAP: begin
                outs.supply    = 1'b1;
                outs.phy_clk   = 1'b1;
                outs.bus_clk   = 1'b1;
                outs.core_clk  = 1'b1;
                outs.phy_pd    = 1'b0;
                outs.ref_clk   = 1'b1;
                outs.ep_assert = 1'b0;
                outs.phy_rst   = 1'b0;
                outs.busy      = 1'b1;
            end
            ST_SOFTREL: begin
                outs.supply    = 1'b1;
                outs.phy_clk   = 1'b1;
                outs.bus_clk   = 1'b1;
                outs.core_clk  = 1'b1;
                outs.phy_pd    = 1'b0;
                outs.ref_clk   = 1'b1;
                outs.ep_assert = 1'b0;
                outs.core_srst = 1'b0;
                outs.busy      = 1'b1;
            end
            ST_FIN, ST_UP: begin
                outs.supply    = 1'b1;
                outs.phy_clk   = 1'b1;
                outs.bus_clk   = 1'b1;
                outs.core_clk  = 1'b1;
                outs.phy_pd    = 1'b0;
                outs.ref_clk   = 1'b1;
                outs.ep_assert = 1'b0;
                outs.phy_rst   = 1'b0;
                outs.core_srst = 1'b0;
                outs.up        = 1'b1;
                outs.done      = (state == ST_FIN);
            end
            ST_DOWN: begin
                outs.supply = 1'b1;
                outs.busy   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
    import prs_pkg::*;
#(
    parameter int SUPPLY_CYC = 100,
    parameter int PD2REF_CYC = 1000,
    parameter int SETTLE_CYC = 30000,
    parameter int EPRST_CYC  = 10000000,
    parameter int GAP_CYC    = 10000,
    parameter int POLL_MAX   = 2000,
    parameter int SOFT_CYC   = 30000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       shutdown_i,
    input  logic       pll_lock_i,
    input  logic       ep_pol_i,
    input  logic [1:0] variant_i,
    output logic       supply_en_o,
    output logic       phy_clk_en_o,
    output logic       bus_clk_en_o,
    output logic       core_clk_en_o,
    output logic       phy_pd_o,
    output logic       ref_clk_en_o,
    output logic       ep_rst_o,
    output logic       phy_rst_o,
    output logic       core_srst_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       up_o,
    output logic       lock_to_o
);

    localparam int LONGEST = prs_max(prs_max(prs_max(SUPPLY_CYC, PD2REF_CYC),
                                             prs_max(SETTLE_CYC, EPRST_CYC)),
                                     prs_max(GAP_CYC, SOFT_CYC));
    localparam int TW = $clog2(LONGEST + 1);

    prs_state_e   state_q, state_d;
    prs_variant_e var_q;
    logic         lock_to_q;
    logic         tmr_zero;
    logic         tmr_load;
    logic [TW-1:0] tmr_val;
    logic         poll_last;
    logic         poll_clear;
    logic         poll_incr;
    prs_out_t     outs;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (shutdown_i && state_q != ST_IDLE && state_q != ST_DOWN) begin
            state_d = ST_DOWN;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start_i && !shutdown_i) state_d = ST_SUPPLY;
                ST_SUPPLY:  if (tmr_zero) state_d = ST_PHYCLK;
                ST_PHYCLK:  state_d = ST_BUSCLK;
                ST_BUSCLK:  state_d = ST_CORECLK;
                ST_CORECLK: state_d = ST_PDREL;
                ST_PDREL:   if (tmr_zero) state_d = ST_SETTLE;
                ST_SETTLE:  if (tmr_zero) state_d = ST_EPHOLD;
                ST_EPHOLD:  if (tmr_zero) state_d = ST_EPREL;
                ST_EPREL: begin
                    unique case (var_q)
                        VAR_PLAIN:   state_d = ST_FIN;
                        VAR_PHYRST:  state_d = ST_PHYREL;
                        VAR_SOFTRST: state_d = ST_SOFTREL;
                        VAR_PLLWAIT: state_d = ST_PHYREL;
                    endcase
                end
                ST_PHYREL:  state_d = (var_q == VAR_PLLWAIT) ? ST_POLL : ST_FIN;
                ST_POLL: begin
                    if (pll_lock_i || poll_last) state_d = ST_FIN;
                    else                         state_d = ST_GAP;
                end
                ST_GAP:     if (tmr_zero) state_d = ST_POLL;
                ST_SOFTREL: if (tmr_zero) state_d = ST_FIN;
                ST_FIN:     state_d = ST_UP;
                ST_UP:      state_d = ST_UP;
                ST_DOWN:    state_d = ST_IDLE;
            endcase
        end
    end

    // Timer reload on every state change, with the dwell of the state entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_SUPPLY:  tmr_val = TW'(SUPPLY_CYC - 1);
            ST_PDREL:   tmr_val = TW'(PD2REF_CYC - 1);
            ST_SETTLE:  tmr_val = TW'(SETTLE_CYC - 1);
            ST_EPHOLD:  tmr_val = TW'(EPRST_CYC - 1);
            ST_GAP:     tmr_val = TW'(GAP_CYC - 1);
            ST_SOFTREL: tmr_val = TW'(SOFT_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    assign poll_clear = (state_q == ST_EPREL);
    assign poll_incr  = (state_q == ST_POLL) && (state_d == ST_GAP);

    prs_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    prs_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .incr  (poll_incr),
        .last  (poll_last)
    );

    // State register, captured variant and timeout flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            var_q     <= VAR_PLAIN;
            lock_to_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_SUPPLY) begin
                var_q     <= prs_variant_e'(variant_i);
                lock_to_q <= 1'b0;
            end else if (state_q == ST_POLL && state_d == ST_FIN && !pll_lock_i) begin
                lock_to_q <= 1'b1;
            end
        end
    end

    prs_out_decode u_dec (
        .state (state_q),
        .outs  (outs)
    );

    assign supply_en_o   = outs.supply;
    assign phy_clk_en_o  = outs.phy_clk;
    assign bus_clk_en_o  = outs.bus_clk;
    assign core_clk_en_o = outs.core_clk;
    assign phy_pd_o      = outs.phy_pd;
    assign ref_clk_en_o  = outs.ref_clk;
    assign ep_rst_o      = outs.ep_assert ? ep_pol_i : ~ep_pol_i;
    assign phy_rst_o     = outs.phy_rst;
    assign core_srst_o   = outs.core_srst;
    assign busy_o        = outs.busy;
    assign done_o        = outs.done;
    assign up_o          = outs.up;
    assign lock_to_o     = lock_to_q;

    // R2: clocks enabled strictly in order
    assert_clk_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_clk_en_o |-> phy_clk_en_o) and (core_clk_en_o |-> bus_clk_en_o));

    // R3: reference clock only with the PHY powered up
    assert_ref_needs_pwr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_clk_en_o |-> !phy_pd_o);

    // R4: endpoint released only with the reference clock running
    assert_ep_after_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_rst_o != ep_pol_i) |-> ref_clk_en_o);

    // R10: done is a single-cycle pulse, never together with busy
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R12: supply drops only after clocks and reference clock are already off
    assert_supply_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en_o) |-> $past(!ref_clk_en_o && !phy_clk_en_o));

    // R13: captured variant stays put while the sequence runs
    assert_var_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(var_q));

endmodule

// File: tb/test_pwrup_rst_seq.sv
module test_pwrup_rst_seq;

    localparam int P_SUP  = 3;
    localparam int P_PD   = 4;
    localparam int P_SET  = 6;
    localparam int P_EP   = 10;
    localparam int P_GAP  = 3;
    localparam int P_NPOL = 4;
    localparam int P_SOFT = 5;
    localparam int BASE   = P_SUP + P_PD + P_SET + P_EP + 4;

    // model stage numbers (ordered along the power-up path)
    localparam int M_IDLE = 0, M_SUP = 1, M_PCLK = 2, M_BCLK = 3, M_CCLK = 4,
                   M_PD = 5, M_SET = 6, M_EP = 7, M_EPR = 8, M_PHR = 9,
                   M_POLL = 10, M_GAP = 11, M_SOFT = 12, M_FIN = 13,
                   M_UP = 14, M_DOWN = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, shutdown_i = 1'b0, pll_lock_i = 1'b0, ep_pol_i = 1'b0;
    logic [1:0] variant_i = 2'd0;
    logic supply_en_o, phy_clk_en_o, bus_clk_en_o, core_clk_en_o, phy_pd_o;
    logic ref_clk_en_o, ep_rst_o, phy_rst_o, core_srst_o, busy_o, done_o, up_o, lock_to_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwrup_rst_seq #(
        .SUPPLY_CYC(P_SUP), .PD2REF_CYC(P_PD), .SETTLE_CYC(P_SET), .EPRST_CYC(P_EP),
        .GAP_CYC(P_GAP), .POLL_MAX(P_NPOL), .SOFT_CYC(P_SOFT)
    ) i_pwrup_rst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
        .pll_lock_i(pll_lock_i), .ep_pol_i(ep_pol_i), .variant_i(variant_i),
        .supply_en_o(supply_en_o), .phy_clk_en_o(phy_clk_en_o), .bus_clk_en_o(bus_clk_en_o),
        .core_clk_en_o(core_clk_en_o), .phy_pd_o(phy_pd_o), .ref_clk_en_o(ref_clk_en_o),
        .ep_rst_o(ep_rst_o), .phy_rst_o(phy_rst_o), .core_srst_o(core_srst_o),
        .busy_o(busy_o), .done_o(done_o), .up_o(up_o), .lock_to_o(lock_to_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_st = M_IDLE;
    int  m_left = 0;
    int  m_polls = 0;
    int  m_var = 0;
    bit  m_lockto = 0;

    task automatic m_go(input int s, input int d);
        m_st = s;
        m_left = d;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = M_IDLE; m_left = 0; m_polls = 0; m_lockto = 0; m_var = 0;
        end else if (shutdown_i && m_st != M_IDLE && m_st != M_DOWN) begin
            m_go(M_DOWN, 1);
        end else if (m_st == M_IDLE) begin
            if (start_i && !shutdown_i) begin
                m_var = int'(variant_i);
                m_lockto = 0;
                m_go(M_SUP, P_SUP);
            end
        end else if (m_st == M_UP) begin
            m_st = M_UP;
        end else if (m_st == M_POLL) begin
            m_polls++;
            if (pll_lock_i) m_go(M_FIN, 1);
            else if (m_polls == P_NPOL) begin
                m_lockto = 1;
                m_go(M_FIN, 1);
            end else m_go(M_GAP, P_GAP);
        end else if (m_left > 1) begin
            m_left--;
        end else begin
            case (m_st)
                M_SUP:  m_go(M_PCLK, 1);
                M_PCLK: m_go(M_BCLK, 1);
                M_BCLK: m_go(M_CCLK, 1);
                M_CCLK: m_go(M_PD, P_PD);
                M_PD:   m_go(M_SET, P_SET);
                M_SET:  m_go(M_EP, P_EP);
                M_EP:   m_go(M_EPR, 1);
                M_EPR: begin
                    if (m_var == 0) m_go(M_FIN, 1);
                    else if (m_var == 2) m_go(M_SOFT, P_SOFT);
                    else m_go(M_PHR, 1);
                end
                M_PHR: begin
                    m_polls = 0;
                    if (m_var == 3) m_go(M_POLL, 1);
                    else m_go(M_FIN, 1);
                end
                M_GAP:  m_go(M_POLL, 1);
                M_SOFT: m_go(M_FIN, 1);
                M_FIN:  m_go(M_UP, 1);
                M_DOWN: m_go(M_IDLE, 0);
                default: m_go(M_IDLE, 0);
            endcase
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            bit on;
            bit epa;
            on  = (m_st >= M_PCLK && m_st <= M_UP);
            chk(supply_en_o == (m_st != M_IDLE), "R2 supply", supply_en_o, m_st != M_IDLE);
            chk(phy_clk_en_o == on, "R2 phy_clk", phy_clk_en_o, on);
            chk(bus_clk_en_o == (m_st >= M_BCLK && m_st <= M_UP), "R2 bus_clk",
                bus_clk_en_o, m_st >= M_BCLK && m_st <= M_UP);
            chk(core_clk_en_o == (m_st >= M_CCLK && m_st <= M_UP), "R2 core_clk",
                core_clk_en_o, m_st >= M_CCLK && m_st <= M_UP);
            chk(phy_pd_o == !(m_st >= M_PD && m_st <= M_UP), "R3 phy_pd",
                phy_pd_o, !(m_st >= M_PD && m_st <= M_UP));
            chk(ref_clk_en_o == (m_st >= M_SET && m_st <= M_UP), "R3 ref_clk",
                ref_clk_en_o, m_st >= M_SET && m_st <= M_UP);
            epa = !(m_st >= M_EPR && m_st <= M_UP);
            chk(ep_rst_o == (epa ? ep_pol_i : !ep_pol_i), "R4 ep_rst",
                ep_rst_o, epa ? ep_pol_i : !ep_pol_i);
            chk(phy_rst_o == !(m_st == M_PHR || m_st == M_POLL || m_st == M_GAP ||
                               m_st == M_FIN || m_st == M_UP), "R6 phy_rst", phy_rst_o, -1);
            chk(core_srst_o == !(m_st == M_SOFT || m_st == M_FIN || m_st == M_UP),
                "R7 core_srst", core_srst_o, -1);
            chk(busy_o == ((m_st >= M_SUP && m_st <= M_SOFT) || m_st == M_DOWN),
                "R10 busy", busy_o, (m_st >= M_SUP && m_st <= M_SOFT) || m_st == M_DOWN);
            chk(done_o == (m_st == M_FIN), "R10 done", done_o, m_st == M_FIN);
            chk(up_o == (m_st == M_FIN || m_st == M_UP), "R6 up", up_o,
                m_st == M_FIN || m_st == M_UP);
            chk(lock_to_o == m_lockto, "R9 lock_to", lock_to_o, m_lockto);
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // ---------------- stimulus ----------------
    task automatic run(input logic [1:0] v, input int lock_n, input int chg_n, output int lat);
        int n;
        n = 0;
        @(negedge clk);
        variant_i = v;
        start_i = 1'b1;
        if (lock_n == 0) pll_lock_i = 1'b1;
        while (1) begin
            @(posedge clk);
            #3;
            n++;
            if (done_o || n > 500) break;
            @(negedge clk);
            start_i = 1'b0;
            if (n == lock_n) pll_lock_i = 1'b1;
            if (n == chg_n) variant_i = ~v;
        end
        lat = n;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic shut();
        @(negedge clk);
        shutdown_i = 1'b1;
        @(negedge clk);
        shutdown_i = 1'b0;
        pll_lock_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        // R1 reset state
        chk(supply_en_o == 0 && phy_clk_en_o == 0 && ref_clk_en_o == 0 && phy_pd_o == 1,
            "R1 power outputs", {supply_en_o, phy_clk_en_o, ref_clk_en_o, phy_pd_o}, 1);
        chk(phy_rst_o && core_srst_o && ep_rst_o == ep_pol_i && !busy_o && !up_o && !lock_to_o,
            "R1 resets/flags", {phy_rst_o, core_srst_o, ep_rst_o, busy_o, up_o, lock_to_o}, 6'b110000);

        // R5 polarity follows in idle
        @(negedge clk); ep_pol_i = 1'b1;
        @(posedge clk); #3;
        chk(ep_rst_o == 1'b1, "R5 active level follows pol", ep_rst_o, 1);

        // R6 variant 0 (plain)
        run(2'd0, -1, -1, lat);
        chk(lat == BASE + 1, "R6 plain latency", lat, BASE + 1);
        chk(ep_rst_o == 1'b0, "R5 released level is inverse", ep_rst_o, 0);
        // R11 start ignored in UP
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(posedge clk); #3;
        chk(up_o && !busy_o && !done_o, "R11 start in UP ignored", {up_o, busy_o, done_o}, 3'b100);
        shut();
        chk(!supply_en_o && !busy_o, "R12 idle after shutdown", {supply_en_o, busy_o}, 0);

        // R6 variant 1 (PHY reset)
        ep_pol_i = 1'b0;
        run(2'd1, -1, -1, lat);
        chk(lat == BASE + 2, "R6 phy-reset latency", lat, BASE + 2);
        shut();

        // R7 variant 2 (soft reset)
        run(2'd2, -1, -1, lat);
        chk(lat == BASE + P_SOFT + 1, "R7 soft-reset latency", lat, BASE + P_SOFT + 1);
        shut();

        // R8 lock on first poll
        run(2'd3, 0, -1, lat);
        chk(lat == BASE + 3, "R8 lock first poll", lat, BASE + 3);
        chk(!lock_to_o, "R8 no timeout", lock_to_o, 0);
        shut();

        // R8 lock on second poll
        run(2'd3, BASE + 3, -1, lat);
        chk(lat == BASE + 4 + P_GAP, "R8 lock second poll", lat, BASE + 4 + P_GAP);
        shut();

        // R9 timeout
        run(2'd3, -1, -1, lat);
        chk(lat == BASE + 3 + (P_NPOL - 1) * (P_GAP + 1), "R9 timeout latency",
            lat, BASE + 3 + (P_NPOL - 1) * (P_GAP + 1));
        chk(lock_to_o == 1'b1, "R9 timeout flag set", lock_to_o, 1);
        shut();
        chk(lock_to_o == 1'b1, "R9 flag kept after shutdown", lock_to_o, 1);

        // R9 lock on the final poll beats the timeout
        run(2'd3, BASE + 3 + (P_NPOL - 2) * (P_GAP + 1), -1, lat);
        chk(lat == BASE + 3 + (P_NPOL - 1) * (P_GAP + 1), "R9 last-poll lock latency",
            lat, BASE + 3 + (P_NPOL - 1) * (P_GAP + 1));
        chk(lock_to_o == 1'b0, "R9 last-poll lock wins, flag clear", lock_to_o, 0);
        shut();

        // R13 variant change mid-sequence ignored (0 -> 3)
        run(2'd0, -1, 5, lat);
        chk(lat == BASE + 1, "R13 captured variant", lat, BASE + 1);
        shut();
        variant_i = 2'd0;

        // R12 shutdown on the SUPPLY expiry edge
        begin
            int n;
            n = 0;
            @(negedge clk);
            start_i = 1'b1;
            while (n < P_SUP) begin
                @(posedge clk); #3; n++;
                @(negedge clk); start_i = 1'b0;
            end
            shutdown_i = 1'b1;
            @(posedge clk); #3;
            chk(!phy_clk_en_o && supply_en_o && busy_o && phy_pd_o, "R12 shutdown wins over expiry",
                {phy_clk_en_o, supply_en_o, busy_o, phy_pd_o}, 4'b0111);
            @(negedge clk); shutdown_i = 1'b0;
            @(posedge clk); #3;
            chk(!supply_en_o && !busy_o, "R12 idle after down", {supply_en_o, busy_o}, 0);
        end

        // R12 shutdown mid-sequence during the endpoint hold
        begin
            @(negedge clk); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            repeat (P_SUP + P_PD + P_SET + 5) @(negedge clk);
            shutdown_i = 1'b1;
            @(posedge clk); #3;
            chk(!ref_clk_en_o && phy_pd_o && phy_rst_o && core_srst_o && !core_clk_en_o &&
                supply_en_o && ep_rst_o == ep_pol_i, "R12 down state outputs",
                {ref_clk_en_o, phy_pd_o, core_clk_en_o, supply_en_o}, 4'b0101);
            @(negedge clk); shutdown_i = 1'b0;
            @(posedge clk); #3;
            chk(!supply_en_o, "R12 supply off after down", supply_en_o, 0);
        end

        // R12 start and shutdown together in IDLE
        @(negedge clk); start_i = 1'b1; shutdown_i = 1'b1;
        @(negedge clk); start_i = 1'b0; shutdown_i = 1'b0;
        @(posedge clk); #3;
        chk(!busy_o && !supply_en_o, "R12 start+shutdown in idle", {busy_o, supply_en_o}, 0);

        // R9 flag cleared by next start (left set? set it again first)
        run(2'd3, -1, -1, lat);
        shut();
        @(negedge clk); variant_i = 2'd0; start_i = 1'b1;
        @(posedge clk); #3;
        chk(lock_to_o == 1'b0, "R9 flag cleared at start", lock_to_o, 0);
        @(negedge clk); start_i = 1'b0;
        repeat (BASE + 3) @(negedge clk);
        shut();

        finished = 1;
        summary();
    end

endmodule